// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Each pin has a direction bit and an output value bit. The block drives pin values and output enables toward the pads. Incoming pin levels pass through a synchroniser before the block reads them or acts on them.

Each pin can raise an interrupt on a high level, a low level, a rising edge, a falling edge or any transition. Three per-pin registers select the trigger. One chooses level or edge, one chooses polarity, and one forces any-edge mode. Detected events latch into a pending bit, and software clears that bit by writing a one to it. A single registered interrupt line is high while any pin is both pending and enabled. A constant version word tells software whether the any-edge register exists.

Access is through a simple 32-bit word bus with separate read and write strobes. Read data is registered and valid one cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: During and after reset, the interrupt enable register is zero and the direction register is all ones, so pin_oe is zero. pin_out is zero, the polarity register is all ones, and irq is low.
- R2: Word offsets are 0x00 pin value, 0x04 direction, 0x08 interrupt enable, 0x0C raw pending, 0x10 masked pending, 0x14 clear, 0x18 edge select, 0x1C polarity and 0x24 any-edge select. A direction bit of 0 makes the pin an output: pin_oe[n] is high and pin_out[n] carries bit n of the value register.
- R3: Reading offset 0x00 returns, in bit n, the level of pin_in[n] after the synchroniser.
- R4: With edge bit 0 and any-edge bit 0, the pin is level-triggered. Its pending bit is set in every cycle in which the synchronised level equals the polarity bit (1 = high, 0 = low).
- R5: With edge bit 1 and any-edge bit 0, the pin is edge-triggered. Polarity 1 sets pending on a rising edge of the synchronised level, and polarity 0 on a falling edge.
- R6: With the any-edge bit 1, every transition of the synchronised level sets pending, whatever the edge and polarity bits hold.
- R7: Writing 1 to bit n at offset 0x14 clears pending bit n, and writing 0 leaves it unchanged. A pending bit falls only after such a write. When a set and a clear reach the same bit in the same cycle, the set wins.
- R8: Pending bits latch events whether or not the pin is enabled. Offset 0x0C returns the pending bits, and offset 0x10 returns pending AND enable.
- R9: irq is a register that goes high the cycle after any bit of (pending AND enable) is set, and low the cycle after none is.
- R10: Offset 0x20 reads the constant 3, offset 0x14 reads 0, and every unmapped offset reads 0. Read data appears on rd_data one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address, word aligned |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin values toward the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 pins, a two-stage synchroniser and version 3. With these values the top pin, bit 31, and the implemented any-edge register are both within reach. The trigger table drives pin 0 through every level, edge and any-edge combination, including any-edge mode with the edge or polarity bits also set. Directed tests cover these cases:
- the split between raw and masked pending,
- a clear written with zeros,
- a clear that collides with a persisting level condition,
- a falling edge on pin 31.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 32;
  localparam int WORD_COUNT = 10;

  typedef enum logic [3:0] {
    IDX_VAL = 4'd0,
    IDX_DIR = 4'd1,
    IDX_IEN = 4'd2,
    IDX_RAW = 4'd3,
    IDX_PND = 4'd4,
    IDX_CLR = 4'd5,
    IDX_EDG = 4'd6,
    IDX_POL = 4'd7,
    IDX_VER = 4'd8,
    IDX_BTH = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pending,
  output logic [W-1:0] lvl_d
);
  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, hit;

    always_comb begin
      rise = lvl[g] & ~lvl_d[g];
      fall = ~lvl[g] & lvl_d[g];
      if (both[g])          hit = rise | fall;
      else if (edge_sel[g]) hit = pol[g] ? rise : fall;
      else                  hit = (lvl[g] == pol[g]);
    end

    always_ff @(posedge clk) begin
      if (rst)         pending[g] <= 1'b0;
      else if (hit)    pending[g] <= 1'b1;
      else if (clr[g]) pending[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int W       = 32,
  parameter int ADDR_W  = 6,
  parameter int VERSION = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      pending,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      edg_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      bth_q,
  output logic [W-1:0]      clr_mask
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             mapped;
  reg_idx_e         idx;
  logic [W-1:0]     wval;
  logic [BUS_W-1:0] rd_next;

  assign widx   = addr[ADDR_W-1:2];
  assign mapped = (widx < IDX_W'(WORD_COUNT));
  assign idx    = reg_idx_e'(widx[3:0]);
  assign wval   = wr_data[W-1:0];

  function automatic logic wr_hit(input reg_idx_e which);
    return wr_en && mapped && (idx == which);
  endfunction

  assign clr_mask = wr_hit(IDX_CLR) ? wval : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '1;
      ien_q <= '0;
      edg_q <= '0;
      pol_q <= '1;
    end else begin
      if (wr_hit(IDX_VAL)) out_q <= wval;
      if (wr_hit(IDX_DIR)) dir_q <= wval;
      if (wr_hit(IDX_IEN)) ien_q <= wval;
      if (wr_hit(IDX_EDG)) edg_q <= wval;
      if (wr_hit(IDX_POL)) pol_q <= wval;
    end
  end

  if (VERSION >= 3) begin : g_both_reg
    always_ff @(posedge clk) begin
      if (rst)                 bth_q <= '0;
      else if (wr_hit(IDX_BTH)) bth_q <= wval;
    end
  end else begin : g_no_both
    assign bth_q = '0;
  end

  always_comb begin
    rd_next = '0;
    if (mapped) begin
      case (idx)
        IDX_VAL: rd_next[W-1:0] = lvl;
        IDX_DIR: rd_next[W-1:0] = dir_q;
        IDX_IEN: rd_next[W-1:0] = ien_q;
        IDX_RAW: rd_next[W-1:0] = pending;
        IDX_PND: rd_next[W-1:0] = pending & ien_q;
        IDX_EDG: rd_next[W-1:0] = edg_q;
        IDX_POL: rd_next[W-1:0] = pol_q;
        IDX_BTH: rd_next[W-1:0] = bth_q;
        IDX_VER: rd_next        = BUS_W'(VERSION);
        default: rd_next        = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int VERSION     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [BUS_W-1:0]    wr_data,
  input  logic                rd_en,
  output logic [BUS_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] lvl_s, lvl_d, pend_w, clr_w;
  logic [NUM_PINS-1:0] out_q, dir_q, ien_q, edg_q, pol_q, bth_q;

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_s)
  );

  gpio_regfile #(.W(NUM_PINS), .ADDR_W(ADDR_W), .VERSION(VERSION)) regs_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .lvl(lvl_s), .pending(pend_w),
    .out_q(out_q), .dir_q(dir_q), .ien_q(ien_q), .edg_q(edg_q),
    .pol_q(pol_q), .bth_q(bth_q), .clr_mask(clr_w)
  );

  gpio_trig_detect #(.W(NUM_PINS)) det_i (
    .clk(clk), .rst(rst), .lvl(lvl_s), .edge_sel(edg_q), .pol(pol_q),
    .both(bth_q), .clr(clr_w), .pending(pend_w), .lvl_d(lvl_d)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend_w & ien_q);
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [31:0]         rd_data,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_PINS-1:0] enable,
  input logic [NUM_PINS-1:0] both,
  input logic [NUM_PINS-1:0] lvl_s,
  input logic [NUM_PINS-1:0] lvl_d
);
  localparam logic [ADDR_W-1:0] OFS_CLR = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_VER = ADDR_W'(8'h20);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!irq && pin_oe == '0));

  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (|($past(pending) & ~pending)) |-> ($past(wr_en) && $past(addr) == OFS_CLR));

  a_r9_irq_rises: assert property (@(posedge clk) disable iff (rst)
    (|(pending & enable)) |=> irq);

  a_r9_irq_falls: assert property (@(posedge clk) disable iff (rst)
    !(|(pending & enable)) |=> !irq);

  a_r6_any_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (|(both & (lvl_s ^ lvl_d))) |=> (|pending));

  a_r10_version: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_VER) |=> rd_data == 32'd3);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .pin_oe(pin_oe), .irq(irq), .pending(pend_w),
  .enable(ien_q), .both(bth_q), .lvl_s(lvl_s), .lvl_d(lvl_d)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08,
                         A_RAW = 6'h0C, A_PND = 6'h10, A_CLR = 6'h14,
                         A_EDG = 6'h18, A_POL = 6'h1C, A_VER = 6'h20,
                         A_BTH = 6'h24, A_UNM = 6'h28;

  // {edge, pol, both, start level, end level, expected pending}
  localparam logic [5:0] VEC [16] = '{
    6'b010_00_0, 6'b010_01_1, 6'b010_10_1, 6'b010_11_1,
    6'b000_00_1, 6'b000_11_0,
    6'b110_01_1, 6'b110_10_0, 6'b110_11_0,
    6'b100_10_1, 6'b100_01_0,
    6'b001_01_1, 6'b001_10_1, 6'b001_11_0, 6'b101_00_0, 6'b011_10_1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, pin_out, pin_oe;
  logic [31:0] pin_in = '0;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    wait_cyc(3);
    check("R1 pin_oe in reset", pin_oe, 32'h0);
    rst = 1'b0;
    wait_cyc(2);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(A_IEN, r); check("R1 enable reg", r, 32'h0);
    bus_rd(A_DIR, r); check("R1 dir reg", r, 32'hFFFF_FFFF);
    bus_rd(A_POL, r); check("R1 pol reg", r, 32'hFFFF_FFFF);

    bus_rd(A_VER, r); check("R10 version", r, 32'd3);
    bus_rd(A_UNM, r); check("R10 unmapped", r, 32'h0);
    bus_rd(A_CLR, r); check("R10 clear reads zero", r, 32'h0);

    bus_wr(A_DIR, 32'hFFFF_0000);
    bus_wr(A_VAL, 32'h0000_A5A5);
    wait_cyc(1);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'h0000_A5A5);

    pin_in = 32'h1234_5678;
    wait_cyc(4);
    bus_rd(A_VAL, r); check("R3 value read", r, 32'h1234_5678);
    pin_in = '0;
    wait_cyc(4);

    // Trigger table on pin 0
    for (int i = 0; i < 16; i++) begin
      logic [5:0] v;
      string tag;
      v = VEC[i];
      bus_wr(A_EDG, {31'b0, v[5]});
      bus_wr(A_POL, {31'b0, v[4]});
      bus_wr(A_BTH, {31'b0, v[3]});
      pin_in[0] = v[2];
      wait_cyc(6);
      bus_wr(A_CLR, 32'h1);
      pin_in[0] = v[1];
      wait_cyc(6);
      bus_rd(A_RAW, r);
      tag = v[3] ? "R6 any-edge" : (v[5] ? "R5 single edge" : "R4 level");
      check($sformatf("%s vec %0d", tag, i), {31'b0, r[0]}, {31'b0, v[0]});
    end

    // Raw versus masked pending, irq gating
    bus_wr(A_BTH, 32'h0);
    bus_wr(A_EDG, 32'h1);
    bus_wr(A_POL, 32'h1);
    pin_in[0] = 1'b0;
    wait_cyc(6);
    bus_wr(A_CLR, 32'hFFFF_FFFF);
    pin_in[0] = 1'b1;
    wait_cyc(6);
    bus_rd(A_RAW, r); check("R8 raw pending latched while disabled", {31'b0, r[0]}, 32'h1);
    bus_rd(A_PND, r); check("R8 masked pending while disabled", {31'b0, r[0]}, 32'h0);
    check("R9 irq low while disabled", {31'b0, irq}, 32'h0);
    bus_wr(A_IEN, 32'h1);
    wait_cyc(3);
    check("R9 irq high once enabled", {31'b0, irq}, 32'h1);
    bus_rd(A_PND, r); check("R8 masked pending once enabled", {31'b0, r[0]}, 32'h1);
    bus_wr(A_CLR, 32'h0);
    bus_rd(A_RAW, r); check("R7 zero clear keeps pending", {31'b0, r[0]}, 32'h1);
    check("R7 zero clear keeps irq", {31'b0, irq}, 32'h1);
    bus_wr(A_CLR, 32'h1);
    wait_cyc(3);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    bus_rd(A_RAW, r); check("R7 one clears pending", {31'b0, r[0]}, 32'h0);

    // Set wins over clear under a persisting high level
    bus_wr(A_EDG, 32'h0);
    wait_cyc(4);
    bus_wr(A_CLR, 32'h1);
    bus_rd(A_RAW, r); check("R7 set wins over clear", {31'b0, r[0]}, 32'h1);
    bus_wr(A_IEN, 32'h0);

    // Falling edge on the top pin
    bus_wr(A_EDG, 32'h8000_0000);
    bus_wr(A_POL, 32'h0);
    pin_in[31] = 1'b1;
    wait_cyc(6);
    bus_wr(A_CLR, 32'h8000_0000);
    bus_rd(A_RAW, r); check("R5 pin31 quiet before edge", {31'b0, r[31]}, 32'h0);
    pin_in[31] = 1'b0;
    wait_cyc(6);
    bus_rd(A_RAW, r); check("R5 pin31 falling edge", {31'b0, r[31]}, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule